// File: doc/BRIEF.md
# Aliased PHY Control Register File

This block is the register store that a transceiver exposes to its link controller over a simple address/data access port. It holds fixed identity bytes, several control registers, edge-select masks for the line-status interrupts, a free scratch byte, a live view of the two line-state bits and a sticky interrupt status byte. Every writable register occupies three consecutive addresses. A write at the first address loads the register. A write at the second ORs the data into it. A write at the third clears every bit that is one in the data. A read at any of the three returns the current value.

Five status inputs are watched for edges: host disconnect, bus-voltage valid, session valid, session end and ID grounded. A status bit latches when its input shows a rising edge that the rising mask enables, or a falling edge that the falling mask enables. Reading the status byte returns it and clears it in the same access. A separate pulse from the power manager forces the suspend-control bit of the function register high when low-power mode ends.

Top module: `phy_regfile`

## Requirements
- R1: Addresses 00h/01h return the low/high byte of the vendor identity and 02h/03h the low/high byte of the product identity (defaults A1B2h and C3D4h). Writes to these addresses are ignored.
- R2: The function register sits at 04h..06h, the interface register at 07h..09h, the rising mask at 0Dh..0Fh, the falling mask at 10h..12h and the scratch byte at 16h..18h. For each, a write at base loads the value, a write at base+1 ORs the data in, a write at base+2 clears the bits that are one in the data, and a read at any of the three returns the value.
- R3: Interface register bit 2 and mask bits 7:5 are reserved. They always read zero and writes to them are ignored.
- R4: reg_rdata takes the addressed value on the clock edge where reg_rd is high, so it is valid from the next cycle on. It holds its value while reg_rd is low.
- R5: A read at 15h returns line_state in bits 1:0 and zeros in bits 7:2.
- R6: Status bit order is 0 host disconnect, 1 bus-voltage valid, 2 session valid, 3 session end, 4 ID grounded, and bits 7:5 read zero. A 0-to-1 change on an input whose rising-mask bit is set latches its status bit.
- R7: A 1-to-0 change on an input whose falling-mask bit is set latches its status bit.
- R8: An edge whose mask bit is clear leaves the status bit at zero.
- R9: A read at 13h returns the status byte and clears it. An edge that latches in the same cycle as the clearing read stays set.
- R10: A pulse on lp_exit sets function register bit 6. It wins over a clear of that bit in the same cycle.
- R11: Reads at unimplemented addresses (0Ah..0Ch, 14h, 19h..3Fh) return zero, and writes to them change no register.
- R12: After reset: function 41h, interface 00h, both masks 1Fh, scratch 00h, status 00h, reg_rdata 00h. Status inputs count as low at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, registered |
| line_state | input | 2 | Live line state |
| host_disc | input | 1 | Host disconnect detected |
| vbus_valid | input | 1 | Bus voltage valid |
| sess_valid | input | 1 | Session valid |
| sess_end | input | 1 | Session end |
| id_gnd | input | 1 | ID pin grounded |
| lp_exit | input | 1 | One-cycle pulse when low-power mode ends |

## Verification
The assertions assume that the five status inputs and line_state change only between clock edges and stay steady across each edge. They also assume that lp_exit is a single-cycle pulse. The status-clear property additionally needs the status inputs to be steady across the read, so that no edge is latched at the same moment. The stimulus changes inputs only at falling clock edges and deliberately breaks that steadiness in one case, the read-with-event case. There the property's $stable guard keeps the assertion out of play while the bench checks the surviving bit itself.

// File: rtl/phy_regs_pkg.sv
package phy_regs_pkg;

    localparam int AW      = 6;
    localparam int DW      = 8;
    localparam int N_ALIAS = 5;
    localparam int N_EVT   = 5;

    localparam logic [AW-1:0] A_VID_LO = 6'h00;
    localparam logic [AW-1:0] A_VID_HI = 6'h01;
    localparam logic [AW-1:0] A_PID_LO = 6'h02;
    localparam logic [AW-1:0] A_PID_HI = 6'h03;
    localparam logic [AW-1:0] A_FUNC   = 6'h04;
    localparam logic [AW-1:0] A_IFC    = 6'h07;
    localparam logic [AW-1:0] A_ENR    = 6'h0D;
    localparam logic [AW-1:0] A_ENF    = 6'h10;
    localparam logic [AW-1:0] A_STAT   = 6'h13;
    localparam logic [AW-1:0] A_DBG    = 6'h15;
    localparam logic [AW-1:0] A_SCR    = 6'h16;

    // aliased register slots, index 0 first
    localparam logic [N_ALIAS*AW-1:0] BASE_VEC  = {A_SCR, A_ENF, A_ENR, A_IFC, A_FUNC};
    localparam logic [N_ALIAS*DW-1:0] RESET_VEC = {8'h00, 8'h1F, 8'h1F, 8'h00, 8'h41};
    localparam logic [N_ALIAS*DW-1:0] MASK_VEC  = {8'hFF, 8'h1F, 8'h1F, 8'hFB, 8'hFF};
    localparam int SLOT_FUNC   = 0;
    localparam int SLOT_ENR    = 2;
    localparam int SLOT_ENF    = 3;
    localparam int SUSPEND_BIT = 6;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_LOAD,
        OP_SET,
        OP_CLR
    } alias_op_e;

    // status input bundle; last member is bit 0
    typedef struct packed {
        logic id_gnd;
        logic sess_end;
        logic sess_valid;
        logic vbus_valid;
        logic host_disc;
    } otg_evt_t;

    function automatic logic in_alias(input logic [AW-1:0] addr, input logic [AW-1:0] base);
        return (addr == base) || (addr == base + 6'd1) || (addr == base + 6'd2);
    endfunction

    function automatic alias_op_e alias_decode(input logic [AW-1:0] addr,
                                               input logic [AW-1:0] base,
                                               input logic          wr);
        alias_op_e op;
        op = OP_NONE;
        if (wr) begin
            if (addr == base)              op = OP_LOAD;
            else if (addr == base + 6'd1)  op = OP_SET;
            else if (addr == base + 6'd2)  op = OP_CLR;
        end
        return op;
    endfunction

endpackage

// File: rtl/phy_alias_reg.sv
module phy_alias_reg
    import phy_regs_pkg::*;
#(
    parameter int              W        = 8,
    parameter logic [W-1:0]    RST_VAL  = '0,
    parameter logic [W-1:0]    BIT_MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  alias_op_e    op,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    logic [W-1:0] sw_next;

    always_comb begin
        unique case (op)
            OP_LOAD: sw_next = wdata;
            OP_SET:  sw_next = q | wdata;
            OP_CLR:  sw_next = q & ~wdata;
            default: sw_next = q;
        endcase
    end

    // hardware set is applied after the software update, so it wins
    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL & BIT_MASK;
        else     q <= (sw_next | hw_set) & BIT_MASK;
    end
endmodule

// File: rtl/phy_irq_status.sv
module phy_irq_status #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sense,
    input  logic [N-1:0] en_rise,
    input  logic [N-1:0] en_fall,
    input  logic         clr,
    output logic [N-1:0] evt,
    output logic [N-1:0] status
);
    logic [N-1:0] prev;

    assign evt = (sense & ~prev & en_rise) | (~sense & prev & en_fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= '0;
            status <= '0;
        end else begin
            prev   <= sense;
            status <= (clr ? '0 : status) | evt;
        end
    end
endmodule

// File: rtl/phy_read_mux.sv
module phy_read_mux
    import phy_regs_pkg::*;
#(
    parameter logic [15:0] VID = 16'hA1B2,
    parameter logic [15:0] PID = 16'hC3D4
) (
    input  logic [AW-1:0]         addr,
    input  logic [N_ALIAS*DW-1:0] regs,
    input  logic [N_EVT-1:0]      status,
    input  logic [1:0]            line_state,
    output logic [DW-1:0]         data
);
    always_comb begin
        data = '0;
        case (addr)
            A_VID_LO: data = VID[7:0];
            A_VID_HI: data = VID[15:8];
            A_PID_LO: data = PID[7:0];
            A_PID_HI: data = PID[15:8];
            A_STAT:   data = {{(DW-N_EVT){1'b0}}, status};
            A_DBG:    data = {{(DW-2){1'b0}}, line_state};
            default: begin
                for (int i = 0; i < N_ALIAS; i++) begin
                    if (in_alias(addr, BASE_VEC[i*AW +: AW]))
                        data = regs[i*DW +: DW];
                end
            end
        endcase
    end
endmodule

// File: rtl/phy_regfile.sv
module phy_regfile
    import phy_regs_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'hA1B2,
    parameter logic [15:0] PRODUCT_ID = 16'hC3D4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          reg_rd,
    output logic [DW-1:0] reg_rdata,
    input  logic [1:0]    line_state,
    input  logic          host_disc,
    input  logic          vbus_valid,
    input  logic          sess_valid,
    input  logic          sess_end,
    input  logic          id_gnd,
    input  logic          lp_exit
);
    logic [N_ALIAS*DW-1:0] reg_q_flat;
    logic [N_EVT-1:0]      irq_q;
    logic [N_EVT-1:0]      irq_evt;
    otg_evt_t              sense_s;
    logic [N_EVT-1:0]      sense_vec;
    logic [DW-1:0]         mux_data;
    logic                  stat_clr;

    assign sense_s = '{id_gnd: id_gnd, sess_end: sess_end, sess_valid: sess_valid,
                       vbus_valid: vbus_valid, host_disc: host_disc};
    assign sense_vec = sense_s;

    for (genvar i = 0; i < N_ALIAS; i++) begin : g_slot
        logic [DW-1:0] hw;
        if (i == SLOT_FUNC) begin : g_hw
            assign hw = DW'(lp_exit) << SUSPEND_BIT;
        end else begin : g_nohw
            assign hw = '0;
        end
        phy_alias_reg #(
            .W        (DW),
            .RST_VAL  (RESET_VEC[i*DW +: DW]),
            .BIT_MASK (MASK_VEC[i*DW +: DW])
        ) u_reg (
            .clk    (clk),
            .rst    (rst),
            .op     (alias_decode(reg_addr, BASE_VEC[i*AW +: AW], reg_wr)),
            .wdata  (reg_wdata),
            .hw_set (hw),
            .q      (reg_q_flat[i*DW +: DW])
        );
    end

    assign stat_clr = reg_rd && (reg_addr == A_STAT);

    phy_irq_status #(.N(N_EVT)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .sense   (sense_vec),
        .en_rise (reg_q_flat[SLOT_ENR*DW +: N_EVT]),
        .en_fall (reg_q_flat[SLOT_ENF*DW +: N_EVT]),
        .clr     (stat_clr),
        .evt     (irq_evt),
        .status  (irq_q)
    );

    phy_read_mux #(.VID(VENDOR_ID), .PID(PRODUCT_ID)) u_mux (
        .addr       (reg_addr),
        .regs       (reg_q_flat),
        .status     (irq_q),
        .line_state (line_state),
        .data       (mux_data)
    );

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= mux_data;
    end
endmodule

// File: rtl/phy_regfile_chk.sv
module phy_regfile_chk #(
    parameter logic [15:0] VID = 16'hA1B2
) (
    input logic       clk,
    input logic       rst,
    input logic [5:0] reg_addr,
    input logic       reg_rd,
    input logic [7:0] reg_rdata,
    input logic [1:0] line_state,
    input logic       lp_exit,
    input logic [7:0] func_q,
    input logic [4:0] stat_q,
    input logic [4:0] sense
);
    AST_ID_READONLY: assert property (@(posedge clk) disable iff (rst)
        reg_rd && reg_addr == 6'h00 |=> reg_rdata == VID[7:0]);                         // R1
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rd && reg_addr >= 6'h07 && reg_addr <= 6'h09 |=> reg_rdata[2] == 1'b0);     // R3
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));                                                // R4
    AST_DEBUG_LINE: assert property (@(posedge clk) disable iff (rst)
        reg_rd && reg_addr == 6'h15 |=> reg_rdata == {6'b0, $past(line_state)});        // R5
    AST_STATUS_UPPER: assert property (@(posedge clk) disable iff (rst)
        reg_rd && reg_addr == 6'h13 |=> reg_rdata[7:5] == 3'b000);                      // R6
    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        reg_rd && reg_addr == 6'h13 && $stable(sense) |=> stat_q == 5'b0);              // R9
    AST_SUSPEND_SET: assert property (@(posedge clk) disable iff (rst)
        lp_exit |=> func_q[6]);                                                         // R10
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rd && reg_addr >= 6'h19 |=> reg_rdata == 8'h00);                            // R11
endmodule

bind phy_regfile phy_regfile_chk #(.VID(VENDOR_ID)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .line_state (line_state),
    .lp_exit    (lp_exit),
    .func_q     (reg_q_flat[7:0]),
    .stat_q     (irq_q),
    .sense      (sense_vec)
);

// File: tb/tb_phy_regfile.sv
module tb_phy_regfile;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic [1:0] line_state = '0;
    logic       host_disc = 0, vbus_valid = 0, sess_valid = 0, sess_end = 0, id_gnd = 0;
    logic       lp_exit = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_d = 1'b0;

    always #2.5 clk = ~clk;

    phy_regfile dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .line_state(line_state),
        .host_disc(host_disc), .vbus_valid(vbus_valid), .sess_valid(sess_valid),
        .sess_end(sess_end), .id_gnd(id_gnd), .lp_exit(lp_exit)
    );

    // monitor: a read strobed at one edge shows at the next falling edge
    always @(posedge clk) rd_d <= rst ? 1'b0 : reg_rd;

    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (reg_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata=%02h expected=%02h", t, reg_rdata, e);
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] e, input string t);
        n_chk++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: got=%02h expected=%02h", t, act, e);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(reg_rdata, 8'h00, "R12 rdata after reset");
        rd(6'h04, 8'h41, "R12 func reset");
        rd(6'h07, 8'h00, "R12 ifc reset");
        rd(6'h0D, 8'h1F, "R12 rise mask reset");
        rd(6'h10, 8'h1F, "R12 fall mask reset");
        rd(6'h16, 8'h00, "R12 scratch reset");
        rd(6'h13, 8'h00, "R12 status reset");

        rd(6'h00, 8'hB2, "R1 vid lo");
        rd(6'h01, 8'hA1, "R1 vid hi");
        rd(6'h02, 8'hD4, "R1 pid lo");
        rd(6'h03, 8'hC3, "R1 pid hi");
        wr(6'h00, 8'hFF);
        rd(6'h00, 8'hB2, "R1 write ignored");

        wr(6'h04, 8'h05);  rd(6'h04, 8'h05, "R2 func load");
        wr(6'h05, 8'h10);  rd(6'h04, 8'h15, "R2 func set");
        wr(6'h06, 8'h04);  rd(6'h05, 8'h11, "R2 func clear, read set alias");
        wr(6'h16, 8'hA5);  rd(6'h18, 8'hA5, "R2 scratch load");
        wr(6'h17, 8'h5A);  rd(6'h16, 8'hFF, "R2 scratch set");
        wr(6'h18, 8'h0F);  rd(6'h17, 8'hF0, "R2 scratch clear");

        wr(6'h07, 8'hFF);  rd(6'h07, 8'hFB, "R3 ifc reserved bit");
        wr(6'h09, 8'h01);  rd(6'h08, 8'hFA, "R2 ifc clear");
        wr(6'h08, 8'h04);  rd(6'h09, 8'hFA, "R3 ifc set reserved");
        wr(6'h0D, 8'hFF);  rd(6'h0D, 8'h1F, "R3 rise mask reserved");
        wr(6'h0F, 8'h02);  rd(6'h0E, 8'h1D, "R2 rise mask clear");
        wr(6'h12, 8'h1F);  rd(6'h10, 8'h00, "R2 fall mask clear");
        wr(6'h11, 8'hE8);  rd(6'h12, 8'h08, "R3 fall mask set reserved");

        // R4 hold
        rd(6'h16, 8'hF0, "R4 read value");
        repeat (3) @(negedge clk);
        chk(reg_rdata, 8'hF0, "R4 rdata held");

        // R5 debug
        line_state = 2'b10; rd(6'h15, 8'h02, "R5 line 10");
        line_state = 2'b01; rd(6'h15, 8'h01, "R5 line 01");

        // R6/R8: vbus rise masked off, session-valid rise enabled
        @(negedge clk); vbus_valid = 1'b1; sess_valid = 1'b1;
        rd(6'h13, 8'h04, "R6 R8 rise latch");
        rd(6'h13, 8'h00, "R9 cleared by read");
        @(negedge clk); sess_end = 1'b1;
        rd(6'h13, 8'h08, "R6 sess_end rise");
        @(negedge clk); sess_end = 1'b0;
        rd(6'h13, 8'h08, "R7 sess_end fall");
        @(negedge clk); sess_valid = 1'b0;
        rd(6'h13, 8'h00, "R8 masked fall");
        @(negedge clk); host_disc = 1'b1;
        rd(6'h13, 8'h01, "R6 host_disc rise");

        // R9 event on the clearing read
        @(negedge clk);
        reg_addr = 6'h13; reg_rd = 1'b1; id_gnd = 1'b1;
        exp_q.push_back(8'h00); tag_q.push_back("R9 read during event");
        @(negedge clk); reg_rd = 1'b0;
        rd(6'h13, 8'h10, "R9 event survives clear");

        // R10
        @(negedge clk); lp_exit = 1'b1;
        @(negedge clk); lp_exit = 1'b0;
        rd(6'h06, 8'h51, "R10 suspend set");
        @(negedge clk);
        reg_addr = 6'h06; reg_wdata = 8'h40; reg_wr = 1'b1; lp_exit = 1'b1;
        @(negedge clk); reg_wr = 1'b0; lp_exit = 1'b0;
        rd(6'h04, 8'h51, "R10 set beats clear");

        // R11
        wr(6'h0A, 8'hFF);  rd(6'h0A, 8'h00, "R11 unmapped 0A");
        wr(6'h14, 8'hFF);  rd(6'h14, 8'h00, "R11 unmapped 14");
        wr(6'h3F, 8'hFF);  rd(6'h3F, 8'h00, "R11 unmapped 3F");
        rd(6'h16, 8'hF0, "R11 scratch untouched");
        rd(6'h04, 8'h51, "R11 func untouched");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule